// File: doc/BRIEF.md
# Quad Programmable Tap Delay Line

The block has four single-bit channels. Each channel drives its output with a non-inverted copy of its input, delayed by a whole number of clock cycles that software picks. The delay of a channel is a fixed base latency plus a 4-bit step index multiplied by a step length. The base latency and the step length are parameters given in clock cycles, each at least 1. Every channel has a clocked chain of flops: a base segment, then fifteen equal step segments. A tap is taken at the end of the base segment and at the end of each step segment, and a multiplexer picks the tap named by the channel's step index.

Step indices and per-channel output enables come in as parallel words. They are captured into the active configuration only on a one-cycle load strobe. A disabled channel models a floating output: its valid flag is low and its data output is held at 0. The chains keep shifting whatever the enables are. Changing a tap while the input is toggling can produce a spurious edge. Users should hold each input idle for at least the longest programmed delay before they load new step indices.

Top module: `qtd_quad_delay`

## Requirements
- R1: While reset is asserted, and after reset until the first load, every `vld_o` bit and every `dout_o` bit is 0.
- R2: For an enabled channel c with step index A, `dout_o[c]` in cycle m equals the value `din_i[c]` held in cycle m − (BASE_CYC + A·STEP_CYC). Inputs from before reset count as 0.
- R3: Rising and falling input edges take the same delay, so pulse widths are preserved and the output is never inverted.
- R4: Each channel's delay depends only on its own step index and enable bit.
- R5: When a channel's active enable bit is 0, its `vld_o` bit is 0 and its `dout_o` bit is 0. When the bit is 1, its `vld_o` bit is 1.
- R6: Changes on `addr_i` and `en_i` while `load_i` is low have no effect on any output.
- R7: Values present on `addr_i`/`en_i` in a cycle where `load_i` is high are used from the next cycle onward.
- R8: Step index 0 gives the minimum delay BASE_CYC. Step index 15 gives the maximum delay BASE_CYC + 15·STEP_CYC.
- R9: The step index of channel c is `addr_i[4c+3:4c]`, most significant bit first, and its enable is `en_i[c]`.
- R10: The delay chains keep shifting while a channel is disabled. On the first cycle after it is re-enabled, the output already shows the input delayed by the programmed amount.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Configuration load strobe |
| addr_i | input | NUM_CH*4 | Packed step indices, channel c at bits [4c+3:4c] |
| en_i | input | NUM_CH | Per-channel output enables |
| din_i | input | NUM_CH | Channel inputs |
| dout_o | output | NUM_CH | Delayed channel outputs, 0 when disabled |
| vld_o | output | NUM_CH | Channel output valid (low models high impedance) |

## Verification
The assertions check four things on every cycle:
- a disabled channel outputs 0;
- the valid flags change only one cycle after a load;
- the valid flags then match the enables that were loaded;
- once a channel's input has been constant for longer than the maximum delay, the output equals that input, whatever tap is selected.

The exact cycle-accurate delay for each step index needs the bench. It keeps a per-cycle history of the inputs and compares every output in every cycle. The same applies to equal treatment of edges, to retaining history across a disable, and to the cycle on which a new tap becomes active.

// File: rtl/qtd_pkg.sv
package qtd_pkg;
  localparam int ADDR_W   = 4;
  localparam int NUM_TAPS = 1 << ADDR_W;

  typedef struct packed {
    logic              en;
    logic [ADDR_W-1:0] addr;
  } chan_cfg_t;
endpackage

// File: rtl/qtd_cfg_bank.sv
module qtd_cfg_bank
  import qtd_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     load_i,
  input  logic [NUM_CH*ADDR_W-1:0] addr_i,
  input  logic [NUM_CH-1:0]        en_i,
  output chan_cfg_t                cfg_o [NUM_CH]
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    chan_cfg_t cfg_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_q <= '0;
      end else if (load_i) begin
        cfg_q.en   <= en_i[c];
        cfg_q.addr <= addr_i[c*ADDR_W +: ADDR_W];
      end
    end
    assign cfg_o[c] = cfg_q;
  end
endmodule

// File: rtl/qtd_step_chain.sv
module qtd_step_chain
  import qtd_pkg::*;
#(
  parameter int BASE_CYC = 2,
  parameter int STEP_CYC = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                din_i,
  output logic [NUM_TAPS-1:0] taps_o
);
  localparam int LEN = BASE_CYC + (NUM_TAPS - 1) * STEP_CYC;

  logic [LEN-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[LEN-2:0], din_i};
  end

  // tap 0 ends the base segment, tap k ends step segment k
  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
    localparam int IDX = BASE_CYC - 1 + k * STEP_CYC;
    assign taps_o[k] = sr_q[IDX];
  end
endmodule

// File: rtl/qtd_tap_sel.sv
module qtd_tap_sel
  import qtd_pkg::*;
(
  input  logic [NUM_TAPS-1:0] taps_i,
  input  chan_cfg_t           cfg_i,
  output logic                dout_o,
  output logic                vld_o
);
  always_comb begin
    vld_o  = cfg_i.en;
    dout_o = cfg_i.en ? taps_i[cfg_i.addr] : 1'b0;
  end
endmodule

// File: rtl/qtd_quad_delay.sv
module qtd_quad_delay
  import qtd_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int BASE_CYC = 2,
  parameter int STEP_CYC = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     load_i,
  input  logic [NUM_CH*ADDR_W-1:0] addr_i,
  input  logic [NUM_CH-1:0]        en_i,
  input  logic [NUM_CH-1:0]        din_i,
  output logic [NUM_CH-1:0]        dout_o,
  output logic [NUM_CH-1:0]        vld_o
);
  chan_cfg_t cfg [NUM_CH];

  qtd_cfg_bank #(.NUM_CH(NUM_CH)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_i),
    .addr_i (addr_i),
    .en_i   (en_i),
    .cfg_o  (cfg)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [NUM_TAPS-1:0] taps;

    qtd_step_chain #(.BASE_CYC(BASE_CYC), .STEP_CYC(STEP_CYC)) u_chain (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .din_i  (din_i[c]),
      .taps_o (taps)
    );

    qtd_tap_sel u_sel (
      .taps_i (taps),
      .cfg_i  (cfg[c]),
      .dout_o (dout_o[c]),
      .vld_o  (vld_o[c])
    );
  end
endmodule

// File: rtl/qtd_quad_delay_chk.sv
module qtd_quad_delay_chk #(
  parameter int NUM_CH   = 4,
  parameter int BASE_CYC = 2,
  parameter int STEP_CYC = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              load_i,
  input logic [NUM_CH-1:0] en_i,
  input logic [NUM_CH-1:0] din_i,
  input logic [NUM_CH-1:0] dout_o,
  input logic [NUM_CH-1:0] vld_o
);
  localparam int LEN = BASE_CYC + 15 * STEP_CYC;
  localparam int CW  = $clog2(LEN + 2);

  // valid flags move only one cycle after a load (R6)
  p_cfg_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(load_i)) |-> $stable(vld_o));

  // loaded enables appear on the next cycle (R7)
  p_vld_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(load_i)) |-> (vld_o == $past(en_i)));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic          prev_q;
    logic [CW-1:0] run_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q <= 1'b0;
        run_q  <= '0;
      end else begin
        prev_q <= din_i[c];
        if (din_i[c] != prev_q)   run_q <= '0;
        else if (run_q < CW'(LEN)) run_q <= run_q + 1'b1;
      end
    end

    // disabled channel is quiet (R5)
    p_quiet_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !vld_o[c] |-> !dout_o[c]);

    // after a long idle input every tap holds that level (R2)
    p_settled_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_q >= CW'(LEN) && vld_o[c]) |-> (dout_o[c] == prev_q));
  end
endmodule

bind qtd_quad_delay qtd_quad_delay_chk #(
  .NUM_CH   (NUM_CH),
  .BASE_CYC (BASE_CYC),
  .STEP_CYC (STEP_CYC)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .load_i (load_i),
  .en_i   (en_i),
  .din_i  (din_i),
  .dout_o (dout_o),
  .vld_o  (vld_o)
);

// File: tb/tb_qtd_quad_delay.sv
module tb_qtd_quad_delay;
  localparam int NCH  = 4;
  localparam int BASE = 3;
  localparam int STEP = 2;

  logic            clk_i  = 1'b0;
  logic            rst_ni = 1'b0;
  logic            load_i = 1'b0;
  logic [NCH*4-1:0] addr_i = '0;
  logic [NCH-1:0]  en_i   = '0;
  logic [NCH-1:0]  din_i  = '0;
  logic [NCH-1:0]  dout_o;
  logic [NCH-1:0]  vld_o;

  qtd_quad_delay #(.NUM_CH(NCH), .BASE_CYC(BASE), .STEP_CYC(STEP)) dut (
    .clk_i (clk_i), .rst_ni (rst_ni), .load_i (load_i), .addr_i (addr_i),
    .en_i (en_i), .din_i (din_i), .dout_o (dout_o), .vld_o (vld_o)
  );

  always #2 clk_i = ~clk_i;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [NCH-1:0] hist [0:4095];
  logic [NCH-1:0] cur_en = '0;
  logic [3:0]     cur_addr [NCH];
  logic           pend = 1'b0;
  logic [NCH-1:0] pend_en = '0;
  logic [NCH*4-1:0] pend_addr = '0;
  logic [15:0]    lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cycle=%0d actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  function automatic logic [NCH-1:0] rnd();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[NCH-1:0];
  endfunction

  function automatic logic exp_bit(input int c);
    int idx;
    idx = cyc - (BASE + int'(cur_addr[c]) * STEP);
    return (idx < 0) ? 1'b0 : hist[idx][c];
  endfunction

  // one clock cycle: drive d (and strobe), then compare every channel
  task automatic step(input logic [NCH-1:0] d, input logic ld, input string req);
    @(posedge clk_i);
    cyc++;
    if (pend) begin
      cur_en = pend_en;
      for (int c = 0; c < NCH; c++) cur_addr[c] = pend_addr[c*4 +: 4];
      pend = 1'b0;
    end
    #1;
    din_i  = d;
    load_i = ld;
    if (ld) begin
      pend = 1'b1; pend_en = en_i; pend_addr = addr_i;
    end
    hist[cyc] = d;
    @(negedge clk_i);
    for (int c = 0; c < NCH; c++) begin
      if (cur_en[c]) begin
        logic e;
        e = exp_bit(c);
        chk(vld_o[c] && dout_o[c] == e, req, {vld_o[c], dout_o[c]}, {1'b1, e});
      end else begin
        chk(!vld_o[c] && !dout_o[c], req, {vld_o[c], dout_o[c]}, 0);
      end
    end
  endtask

  task automatic load_cfg(input logic [NCH*4-1:0] a, input logic [NCH-1:0] e, input string req);
    addr_i = a;
    en_i   = e;
    step(rnd(), 1'b1, req);
    step(rnd(), 1'b0, req);
  endtask

  task automatic t_reset_state();
    #9;
    chk(vld_o == '0 && dout_o == '0, "R1 in reset", {vld_o, dout_o}, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int i = 0; i < 20; i++) step(rnd(), 1'b0, "R1 before load");
  endtask

  task automatic t_min_delay();
    load_cfg('0, 4'hF, "R8 min load");
    for (int i = 0; i < 50; i++) step(rnd(), 1'b0, "R8 min delay");
  endtask

  task automatic t_max_delay();
    load_cfg({4{4'd15}}, 4'hF, "R8 max load");
    for (int i = 0; i < 70; i++) step(rnd(), 1'b0, "R8 max delay");
  endtask

  task automatic t_mixed();
    load_cfg({4'd3, 4'd12, 4'd7, 4'd1}, 4'hF, "R9 packing");
    for (int i = 0; i < 70; i++) step(rnd(), 1'b0, "R2,R4 per-channel delay");
  endtask

  task automatic t_edges();
    load_cfg({4{4'd5}}, 4'hF, "R3 load");
    for (int i = 0; i < 40; i++) step('0, 1'b0, "R3 idle low");
    for (int w = 1; w <= 6; w++) begin
      for (int i = 0; i < w; i++) step(4'hF, 1'b0, "R3 high pulse");
      for (int i = 0; i < w + 2; i++) step(4'h0, 1'b0, "R3 low gap");
    end
    for (int i = 0; i < 20; i++) step(4'hF, 1'b0, "R3 idle high");
    for (int i = 0; i < 2; i++) step(4'h0, 1'b0, "R3 low pulse");
    for (int i = 0; i < 30; i++) step(4'hF, 1'b0, "R3 recovery");
  endtask

  task automatic t_ignore();
    load_cfg({4'd2, 4'd9, 4'd0, 4'd14}, 4'hF, "R6 load");
    for (int i = 0; i < 40; i++) begin
      step(rnd(), 1'b0, "R6 inputs ignored without strobe");
      addr_i = {rnd(), rnd(), rnd(), rnd()};
      en_i   = rnd();
    end
  endtask

  task automatic t_enable();
    load_cfg({4'd4, 4'd10, 4'd6, 4'd15}, 4'b0101, "R5 partial enable");
    for (int i = 0; i < 40; i++) step(rnd(), 1'b0, "R5 disabled channels quiet");
    load_cfg({4'd4, 4'd10, 4'd6, 4'd15}, 4'hF, "R10 re-enable");
    for (int i = 0; i < 20; i++) step(rnd(), 1'b0, "R10 history kept");
  endtask

  task automatic t_retarget();
    for (int k = 0; k < 6; k++) begin
      logic [NCH*4-1:0] a;
      a = {rnd(), rnd(), rnd(), rnd()};
      load_cfg(a, 4'hF, "R7 new tap next cycle");
      for (int i = 0; i < 10; i++) step(rnd(), 1'b0, "R7 retarget");
    end
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) hist[i] = '0;
    for (int c = 0; c < NCH; c++) cur_addr[c] = '0;
    t_reset_state();
    t_min_delay();
    t_max_delay();
    t_mixed();
    t_edges();
    t_ignore();
    t_enable();
    t_retarget();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule